// File: doc/BRIEF.md
# Split-capable load/store bus master

This block sits between a core's memory stage and a 32-bit request/grant data bus of the open on-chip kind: address phase with `req`/`gnt`, in-order response phase with a one-cycle `rvalid`. It accepts one load or store at a time. Each access carries a size code (byte, halfword or word), a signedness flag for loads, a byte address, store data, and a region attribute that says whether the target is an I/O region. The block places store bytes on the right lanes and builds byte enables from the size and the two low address bits. When the access runs past the end of a 32-bit word, it splits the access into two bus transactions: the lower word first, then the next word. For loads it joins the bytes of the responses, shifts them into place and sign- or zero-extends them.

The sequencer has six named states. `ST_IDLE` waits for a request and is the only state with `req_ready` high. It moves to `ST_FAULT` for a misaligned I/O access and otherwise to `ST_ISSUE_LO`. `ST_ISSUE_LO` requests the lower word. On grant it moves to `ST_ISSUE_HI` if the access is split and to `ST_WAIT_RSP` if not. `ST_ISSUE_HI` requests the following word and moves to `ST_WAIT_RSP` on grant. `ST_WAIT_RSP` collects the remaining responses and moves to `ST_DONE` on the last one. `ST_DONE` and `ST_FAULT` each present the completion for one cycle and then return to `ST_IDLE`. Because the second half is requested without waiting for the first response, a split access can have two transactions in flight. Since a new access is accepted only in `ST_IDLE`, the count never goes above two.

Top module: `lsu_split_master`

## Requirements
- R1: Size code 0 is a byte, 1 a halfword, 2 a word, and 3 is treated as a word. With byte offset o = addr[1:0] and n bytes, the 8-bit mask ((1<<n)-1)<<o gives the byte enables: bits 3:0 for the first transaction and bits 7:4 for the second. Store byte k goes on lane (o+k) mod 4 of the matching transaction, so memory ends up with exactly those n bytes written.
- R2: A word access with o not 0, and a halfword access with o = 3, use two bus transactions. Every other access uses one.
- R3: In a split access, the first transaction addresses the aligned word containing the start address, and the second addresses the next word (address + 4).
- R4: Once `bus_req` is high without grant, it stays high in the next cycle with address, byte enables, write enable and write data unchanged. `bus_reqpar` always equals the inverse of `bus_req`.
- R5: No more than two granted transactions are ever awaiting their response.
- R6: A load returns the n addressed bytes in the low bits of `rsp_rdata`, the lowest address in bits 7:0. The upper bits are copies of the top loaded bit when `req_signed` is 1 and zeros otherwise. A store returns `rsp_rdata` = 0.
- R7: `bus_err` is sampled only with `bus_rvalid`. A split access completes with one `rsp_valid` pulse, and `rsp_err` is the OR of the errors of both halves.
- R8: An I/O access (`req_io` = 1) that is not naturally aligned (halfword with odd address, word with o not 0) issues no bus request and no memory write. It completes with `rsp_fault` = 1 and `rsp_err` = 0. Aligned I/O accesses behave normally.
- R9: After reset, `req_ready` = 1, `bus_req` = 0 and `rsp_valid` = 0. An accepted request drops `req_ready` until completion. It produces exactly one single-cycle `rsp_valid`, and only after every bus response for it has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents an access |
| req_ready | output | 1 | Block is idle and takes the access |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data, low-aligned |
| req_io | input | 1 | Target lies in an I/O region |
| rsp_valid | output | 1 | Access complete (one cycle) |
| rsp_rdata | output | DATA_W | Extended load result, 0 for stores |
| rsp_err | output | 1 | A bus error occurred in any half |
| rsp_fault | output | 1 | Misaligned I/O access refused |
| bus_req | output | 1 | Bus request |
| bus_reqpar | output | 1 | Odd-parity companion of bus_req |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_be | output | DATA_W/8 | Byte enables |
| bus_we | output | 1 | Bus write enable |
| bus_wdata | output | DATA_W | Lane-placed write data |
| bus_gnt | input | 1 | Request accepted |
| bus_rvalid | input | 1 | Response valid |
| bus_rdata | input | DATA_W | Response data |
| bus_err | input | 1 | Response error |

## Verification
A sequencer stuck in or skipping a state shows at the bus within one cycle. Typical signs are a transaction count other than one or two, a request that drops before grant, or a second request to the wrong word. A lost response count shows up as a missing or doubled `rsp_valid`, or a completion while responses are still in flight. Wrong lane or offset logic appears in the very next completion as misplaced load bytes or corrupted neighbouring memory bytes. An error flag that is not accumulated shows up as a clear `rsp_err` when the failing half returned first.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } lsu_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_LO,
        ST_ISSUE_HI,
        ST_WAIT_RSP,
        ST_DONE,
        ST_FAULT
    } lsu_state_e;

    typedef struct packed {
        logic      we;
        lsu_size_e size;
        logic      sgn;
    } lsu_ctl_t;

    // number of bytes an access of the given size touches
    function automatic int size_bytes(input lsu_size_e sz);
        int n;
        unique case (sz)
            SZ_BYTE: n = 1;
            SZ_HALF: n = 2;
            default: n = 4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_split_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int NB     = DATA_W / 8,
    localparam int OFF_W  = $clog2(NB)
) (
    input  lsu_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [NB-1:0]     be_lo,
    output logic [NB-1:0]     be_hi,
    output logic [DATA_W-1:0] wd_lo,
    output logic [DATA_W-1:0] wd_hi,
    output logic              split
);

    logic [NB-1:0]       mask;
    logic [DATA_W-1:0]   wdata_m;
    logic [2*NB-1:0]     wide_be;
    logic [2*DATA_W-1:0] wide_wd;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            mask[i] = (i < size_bytes(size));
        end
    end

    // unused lanes carry zero
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign wdata_m[g*8 +: 8] = mask[g] ? wdata[g*8 +: 8] : 8'h00;
    end

    assign wide_be = {{NB{1'b0}}, mask} << off;
    assign wide_wd = {{DATA_W{1'b0}}, wdata_m} << {off, 3'b000};

    assign be_lo = wide_be[NB-1:0];
    assign be_hi = wide_be[2*NB-1:NB];
    assign wd_lo = wide_wd[DATA_W-1:0];
    assign wd_hi = wide_wd[2*DATA_W-1:DATA_W];
    assign split = |be_hi;

endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge
    import lsu_split_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int NB     = DATA_W / 8,
    localparam int OFF_W  = $clog2(NB)
) (
    input  lsu_size_e         size,
    input  logic              sgn,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] lo_data,
    input  logic [DATA_W-1:0] hi_data,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] raw;
    logic              top_bit;
    int                nbits;

    // bring the addressed bytes down to lane zero
    assign raw = DATA_W'({hi_data, lo_data} >> {off, 3'b000});

    always_comb begin
        nbits = size_bytes(size) * 8;
        unique case (size)
            SZ_BYTE: top_bit = raw[7];
            SZ_HALF: top_bit = raw[15];
            default: top_bit = raw[31];
        endcase
        for (int i = 0; i < DATA_W; i++) begin
            rdata[i] = (i < nbits) ? raw[i] : (sgn & top_bit);
        end
    end

endmodule

// File: rtl/lsu_seq_fsm.sv
module lsu_seq_fsm
    import lsu_split_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_fault,
    input  logic              split,
    input  logic              bus_gnt,
    input  logic              bus_rvalid,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err,
    output logic              idle,
    output logic              bus_req,
    output logic              phase_hi,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_err,
    output logic [DATA_W-1:0] lo_data,
    output logic [DATA_W-1:0] hi_data
);

    lsu_state_e state_q, state_d;
    logic       got_lo_q;
    logic       err_acc_q;
    logic       collecting;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_fault) begin
                    state_d = ST_FAULT;
                end else if (start) begin
                    state_d = ST_ISSUE_LO;
                end
            end
            ST_ISSUE_LO: begin
                if (bus_gnt) begin
                    state_d = split ? ST_ISSUE_HI : ST_WAIT_RSP;
                end
            end
            ST_ISSUE_HI: begin
                if (bus_gnt) begin
                    state_d = ST_WAIT_RSP;
                end
            end
            ST_WAIT_RSP: begin
                if (bus_rvalid && (!split || got_lo_q)) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // responses can only belong to us once the lower half is granted
    assign collecting = (state_q == ST_ISSUE_HI) || (state_q == ST_WAIT_RSP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            got_lo_q  <= 1'b0;
            err_acc_q <= 1'b0;
            lo_data   <= '0;
            hi_data   <= '0;
        end else if (state_q == ST_IDLE && start) begin
            got_lo_q  <= 1'b0;
            err_acc_q <= 1'b0;
            hi_data   <= '0;
        end else if (collecting && bus_rvalid) begin
            if (!got_lo_q) begin
                lo_data  <= bus_rdata;
                got_lo_q <= 1'b1;
            end else begin
                hi_data <= bus_rdata;
            end
            err_acc_q <= err_acc_q | bus_err;
        end
    end

    always_comb begin
        idle      = 1'b0;
        bus_req   = 1'b0;
        phase_hi  = 1'b0;
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            ST_IDLE:     idle = 1'b1;
            ST_ISSUE_LO: bus_req = 1'b1;
            ST_ISSUE_HI: begin
                bus_req  = 1'b1;
                phase_hi = 1'b1;
            end
            ST_WAIT_RSP: phase_hi = split;
            ST_DONE: begin
                rsp_valid = 1'b1;
                rsp_err   = err_acc_q;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default: idle = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsu_split_master.sv
module lsu_split_master
    import lsu_split_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 32,
    localparam int NB     = DATA_W / 8,
    localparam int OFF_W  = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_io,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              rsp_fault,
    output logic              bus_req,
    output logic              bus_reqpar,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [NB-1:0]     bus_be,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_rvalid,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err
);

    lsu_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    logic              accept;
    logic              in_misal;
    logic [OFF_W-1:0]  align_mask;
    lsu_size_e         in_size;

    logic              split;
    logic              phase_hi;
    logic [NB-1:0]     be_lo, be_hi;
    logic [DATA_W-1:0] wd_lo, wd_hi;
    logic [DATA_W-1:0] lo_data, hi_data;
    logic [DATA_W-1:0] merged;
    logic              rsp_valid_i;

    assign in_size    = lsu_size_e'(req_size);
    assign align_mask = OFF_W'(size_bytes(in_size) - 1);
    assign in_misal   = |(req_addr[OFF_W-1:0] & align_mask);
    assign accept     = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '{we: 1'b0, size: SZ_BYTE, sgn: 1'b0};
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            ctl_q   <= '{we: req_we, size: in_size, sgn: req_signed};
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    lsu_seq_fsm #(
        .DATA_W(DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_fault(accept && req_io && in_misal),
        .split      (split),
        .bus_gnt    (bus_gnt),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .bus_err    (bus_err),
        .idle       (req_ready),
        .bus_req    (bus_req),
        .phase_hi   (phase_hi),
        .rsp_valid  (rsp_valid_i),
        .rsp_fault  (rsp_fault),
        .rsp_err    (rsp_err),
        .lo_data    (lo_data),
        .hi_data    (hi_data)
    );

    lsu_lane_align #(
        .DATA_W(DATA_W)
    ) u_align (
        .size (ctl_q.size),
        .off  (addr_q[OFF_W-1:0]),
        .wdata(wdata_q),
        .be_lo(be_lo),
        .be_hi(be_hi),
        .wd_lo(wd_lo),
        .wd_hi(wd_hi),
        .split(split)
    );

    lsu_load_merge #(
        .DATA_W(DATA_W)
    ) u_merge (
        .size   (ctl_q.size),
        .sgn    (ctl_q.sgn),
        .off    (addr_q[OFF_W-1:0]),
        .lo_data(lo_data),
        .hi_data(hi_data),
        .rdata  (merged)
    );

    assign bus_reqpar = ~bus_req;
    assign bus_addr   = {addr_q[ADDR_W-1:OFF_W] + (ADDR_W-OFF_W)'(phase_hi), {OFF_W{1'b0}}};
    assign bus_be     = phase_hi ? be_hi : be_lo;
    assign bus_wdata  = phase_hi ? wd_hi : wd_lo;
    assign bus_we     = ctl_q.we;

    assign rsp_valid  = rsp_valid_i;
    assign rsp_rdata  = (ctl_q.we || rsp_fault) ? '0 : merged;

endmodule

// File: rtl/lsu_split_master_chk.sv
module lsu_split_master_chk #(
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 32,
    localparam int NB     = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              rsp_fault,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NB-1:0]     bus_be,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_gnt,
    input logic              bus_rvalid
);

    logic [1:0]        out_cnt;
    logic              pair_open;
    logic [ADDR_W-1:0] pair_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_cnt   <= '0;
            pair_open <= 1'b0;
            pair_addr <= '0;
        end else begin
            out_cnt <= out_cnt + 2'((bus_req && bus_gnt) ? 1 : 0) - 2'(bus_rvalid ? 1 : 0);
            if (bus_req && bus_gnt) begin
                pair_open <= 1'b1;
                pair_addr <= bus_addr;
            end else if (rsp_valid) begin
                pair_open <= 1'b0;
            end
        end
    end

    a_r4_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_be)
                                   && $stable(bus_we) && $stable(bus_wdata)));

    a_r5_two_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= 2'd2);

    a_r3_second_is_next_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && pair_open) |-> (bus_addr == pair_addr + ADDR_W'(NB)));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    a_r9_done_after_responses: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (out_cnt == 2'd0 && !bus_req && !req_ready));

    a_r8_fault_without_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> ($past(!bus_req) && !rsp_err));

    a_r7_err_with_completion: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

endmodule

bind lsu_split_master lsu_split_master_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_fault (rsp_fault),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_gnt   (bus_gnt),
    .bus_rvalid(bus_rvalid)
);

// File: tb/lsu_split_master_tb_top.sv
`timescale 1ns/1ps
module lsu_split_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0, req_signed = 1'b0, req_io = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err, rsp_fault;
    logic [31:0] rsp_rdata;
    logic        bus_req, bus_reqpar, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_gnt = 1'b0, bus_rvalid = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #10 clk = ~clk;

    lsu_split_master dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_io(req_io),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_fault(rsp_fault),
        .bus_req(bus_req), .bus_reqpar(bus_reqpar), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [31:0] ram [16];
    logic [15:0] lfsr = 16'hACE1;

    // bus model bookkeeping
    int          txn_cnt = 0;
    logic [31:0] txn_addr [2];
    logic [3:0]  txn_be [2];
    bit          hold_bad = 0, parity_bad = 0, outst_bad = 0;
    logic [31:0] q_rd [4];
    bit          q_er [4];
    int          q_cnt [4];
    int          q_n = 0;
    logic        p_req = 0, p_gnt = 0, p_we = 0;
    logic [31:0] p_addr = '0, p_wdata = '0;
    logic [3:0]  p_be = '0;

    localparam int ERR_WORD = 13;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] memb(input logic [31:0] a);
        logic [31:0] w;
        w = ram[a[5:2]];
        return w[{a[1:0], 3'b000} +: 8];
    endfunction

    // memory-side responder: grants at random, answers in order after 1..3 cycles
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                bus_rvalid = 1'b0;
                bus_err    = lfsr[0];
                bus_rdata  = {lfsr, ~lfsr};
                if (q_n > 0) begin
                    if (q_cnt[0] == 0) begin
                        bus_rvalid = 1'b1;
                        bus_rdata  = q_rd[0];
                        bus_err    = q_er[0];
                        for (int i = 0; i < 3; i++) begin
                            q_rd[i]  = q_rd[i+1];
                            q_er[i]  = q_er[i+1];
                            q_cnt[i] = q_cnt[i+1];
                        end
                        q_n--;
                    end else begin
                        q_cnt[0]--;
                    end
                end
                if (p_req && !p_gnt) begin
                    if (!(bus_req && bus_addr == p_addr && bus_be == p_be &&
                          bus_we == p_we && bus_wdata == p_wdata)) hold_bad = 1;
                end
                if (bus_reqpar !== ~bus_req) parity_bad = 1;
                bus_gnt = lfsr[3] | lfsr[7];
                if (bus_req && bus_gnt) begin
                    if (txn_cnt < 2) begin
                        txn_addr[txn_cnt] = bus_addr;
                        txn_be[txn_cnt]   = bus_be;
                    end
                    txn_cnt++;
                    if (bus_we) begin
                        for (int b = 0; b < 4; b++) begin
                            if (bus_be[b]) ram[bus_addr[5:2]][8*b +: 8] = bus_wdata[8*b +: 8];
                        end
                    end
                    if (q_n < 4) begin
                        q_rd[q_n]  = ram[bus_addr[5:2]];
                        q_er[q_n]  = (int'(bus_addr[5:2]) == ERR_WORD);
                        q_cnt[q_n] = int'(lfsr[5:4]) % 3;
                        q_n++;
                    end
                    if (q_n + int'(bus_rvalid) > 2) outst_bad = 1;
                end
                p_req = bus_req; p_gnt = bus_gnt; p_addr = bus_addr;
                p_be = bus_be; p_we = bus_we; p_wdata = bus_wdata;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            end
        end
    end

    task automatic run_case(input bit we, input int sz, input bit sg, input logic [31:0] a,
                            input logic [31:0] wd, input bit io);
        logic [31:0] exp_ram [16];
        logic [63:0] v;
        logic [7:0]  bmask;
        logic [31:0] base;
        int          off, n, waitc;
        bit          split, mis, fexp, eexp;
        off   = int'(a[1:0]);
        n     = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        split = (off + n) > 4;
        mis   = (off % n) != 0;
        fexp  = io && mis;
        eexp  = !fexp && ((int'(a[5:2]) == ERR_WORD) || (split && int'(a[5:2]) + 1 == ERR_WORD));
        base  = {a[31:2], 2'b00};
        bmask = 8'(((1 << n) - 1) << off);
        v = '0;
        for (int k = 0; k < n; k++) v[8*k +: 8] = memb(a + 32'(k));
        if (sg && v[8*n-1]) for (int i = 8*n; i < 32; i++) v[i] = 1'b1;
        for (int i = 0; i < 16; i++) exp_ram[i] = ram[i];
        if (we && !fexp) begin
            for (int k = 0; k < n; k++) begin
                logic [31:0] ak;
                ak = a + 32'(k);
                exp_ram[ak[5:2]][{ak[1:0], 3'b000} +: 8] = wd[8*k +: 8];
            end
        end

        @(negedge clk);
        check(req_ready === 1'b1, "R9 ready while idle", req_ready, 1);
        req_we = we; req_size = 2'(sz); req_signed = sg; req_addr = a;
        req_wdata = wd; req_io = io; req_valid = 1'b1;
        txn_cnt = 0;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready === 1'b0, "R9 ready low while busy", req_ready, 0);
        waitc = 0;
        while (rsp_valid !== 1'b1 && waitc < 300) begin
            @(negedge clk);
            waitc++;
        end
        if (rsp_valid !== 1'b1) begin
            check(1'b0, "R9 no completion", 0, 1);
            return;
        end
        check(rsp_fault === fexp, "R8 fault flag", rsp_fault, fexp);
        check(rsp_err === eexp, "R7 error flag", rsp_err, eexp);
        if (we || fexp) check(rsp_rdata === 32'h0, "R6 store/fault rdata", rsp_rdata, 0);
        else check(rsp_rdata === v[31:0], "R6 load data", rsp_rdata, v[31:0]);
        check(txn_cnt == (fexp ? 0 : (split ? 2 : 1)), "R2 transaction count", txn_cnt,
              fexp ? 0 : (split ? 2 : 1));
        if (!fexp) begin
            check(txn_addr[0] === base, "R3 first address", txn_addr[0], base);
            check(txn_be[0] === bmask[3:0], "R1 first byte enables", txn_be[0], bmask[3:0]);
            if (split) begin
                check(txn_addr[1] === base + 32'd4, "R3 second address", txn_addr[1], base + 32'd4);
                check(txn_be[1] === bmask[7:4], "R1 second byte enables", txn_be[1], bmask[7:4]);
            end
        end
        for (int i = 0; i < 16; i++) begin
            if (ram[i] !== exp_ram[i]) begin
                check(1'b0, we ? "R1 memory after store" : "R8 memory untouched", ram[i], exp_ram[i]);
                break;
            end
        end
        @(negedge clk);
        check(rsp_valid === 1'b0, "R9 completion is one cycle", rsp_valid, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                check(1'b0, "watchdog expired", cyc, 150000);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) ram[i] = 32'h9A3C_71E5 ^ (32'(i) * 32'h1F2E_3D4C);
        repeat (4) @(negedge clk);
        check(req_ready === 1'b1, "R9 reset ready", req_ready, 1);
        check(bus_req === 1'b0, "R9 reset bus_req", bus_req, 0);
        check(rsp_valid === 1'b0, "R9 reset rsp_valid", rsp_valid, 0);
        check(bus_reqpar === 1'b1, "R4 reset parity", bus_reqpar, 1);
        rst_n = 1'b1;

        // sweep: size x offset x kind over two base words
        for (int bw = 2; bw <= 5; bw += 3) begin
            for (int sz = 0; sz < 3; sz++) begin
                for (int off = 0; off < 4; off++) begin
                    logic [31:0] a;
                    a = 32'(bw * 4 + off);
                    run_case(1'b0, sz, 1'b0, a, 32'h0, 1'b0);
                    run_case(1'b0, sz, 1'b1, a, 32'h0, 1'b0);
                    run_case(1'b1, sz, 1'b0, a, 32'hC3A5_1E87 ^ 32'(sz * 16 + off), 1'b0);
                    run_case(1'b0, sz, 1'b1, a, 32'h0, 1'b0);
                end
            end
        end
        // size code 3 acts as a word (R1)
        run_case(1'b0, 3, 1'b0, 32'd41, 32'h0, 1'b0);

        // I/O region: misaligned refused (R8), aligned served
        run_case(1'b0, 1, 1'b0, 32'd33, 32'h0, 1'b1);
        run_case(1'b1, 2, 1'b0, 32'd34, 32'h1122_3344, 1'b1);
        run_case(1'b1, 1, 1'b0, 32'd35, 32'h0000_5566, 1'b1);
        run_case(1'b0, 2, 1'b1, 32'd36, 32'h0, 1'b1);
        run_case(1'b1, 0, 1'b0, 32'd39, 32'h0000_0077, 1'b1);
        run_case(1'b0, 1, 1'b1, 32'd38, 32'h0, 1'b1);

        // bus errors in either half (R7)
        run_case(1'b0, 2, 1'b0, 32'(ERR_WORD * 4 + 2), 32'h0, 1'b0);
        run_case(1'b1, 2, 1'b0, 32'((ERR_WORD - 1) * 4 + 1), 32'hDEAD_BEEF, 1'b0);
        run_case(1'b0, 0, 1'b1, 32'(ERR_WORD * 4 + 1), 32'h0, 1'b0);
        run_case(1'b0, 1, 1'b0, 32'((ERR_WORD - 1) * 4 + 3), 32'h0, 1'b0);

        check(hold_bad == 0, "R4 request held until grant", hold_bad, 0);
        check(parity_bad == 0, "R4 request parity", parity_bad, 0);
        check(outst_bad == 0, "R5 outstanding limit", outst_bad, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule